// File: doc/BRIEF.md
# Paged CAM Address Translator

This block turns a 25-bit logical RAM address into a 22-bit physical address. It holds one entry for each of 128 physical pages. Each entry is loaded from a 23-bit write word. That word packs three things: the physical page number, the logical page the physical page appears at, and a two-bit protection code. Because entries are indexed by physical page and not by logical page, every lookup compares the requested logical page against all 128 entries in parallel.

Page size is selectable at 4, 8, 16 or 32 KB. It changes both how page numbers are packed in the write word and where the in-page offset ends. Each access is classed as supervisor, OS or user, and as a read or a write. That combination, together with the protection code of the matched entry, decides whether the access is allowed. A request that finds no entry, or is not allowed, raises an abort. The result is registered and appears one cycle after the request.

Top module: `page_cam_xlat`

## Requirements
- R1: After rst_ni is asserted, every entry is invalid and rsp_valid_o, rsp_hit_o, rsp_abort_o and rsp_paddr_o are zero. A lookup made before any write therefore misses.
- R2: A request with req_valid_i high at a rising edge produces rsp_valid_o high in the following cycle. When req_valid_i is low at an edge, rsp_valid_o, rsp_hit_o and rsp_abort_o are low and rsp_paddr_o is zero in the following cycle.
- R3: A write (wr_en_i high) stores wr_word_i bits [22:8] in the entry whose index is the physical page decoded from the word under the current page_size_i, and marks that entry valid. A later write to the same index replaces it entirely.
- R4: Physical page decode from write-word bits W: 4 KB gives W[6:0]. 8 KB gives {W[0],W[6:1]}. 16 KB gives {W[1:0],W[6:2]}. 32 KB gives {W[1],W[2],W[0],W[6:3]}.
- R5: Logical page of an entry: 4 KB gives {W[11:10],W[22:12]}. 8 KB gives {W[11:10],W[22:13]}. 16 KB gives {W[11:10],W[22:14]}. 32 KB gives {W[11:10],W[22:15]}. The logical page of a request is req_addr_i[24:12+s].
- R6: page_size_i code s selects the page size: 0 = 4 KB, 1 = 8 KB, 2 = 16 KB, 3 = 32 KB. On a hit, rsp_paddr_o = (matched index << (12+s)) | req_addr_i[11+s:0].
- R7: req_trans_i low makes the access supervisor class. A supervisor access that hits is never aborted, for reads and for writes.
- R8: req_trans_i high with os_mode_i high is OS class; req_trans_i high with os_mode_i low is user class. The protection code is W[9:8]. Code 00 lets OS and user read and write. Code 01 lets OS read and write and lets user only read. Codes 10 and 11 let OS only read and deny user entirely.
- R9: A request that matches no valid entry responds with rsp_hit_o = 0, rsp_abort_o = 1 and rsp_paddr_o = 0. A hit that is not permitted responds with rsp_hit_o = 1, rsp_abort_o = 1 and the translated address.
- R10: When several valid entries hold the requested logical page, the one with the lowest index wins.
- R11: The page size in force at lookup decides the logical page of both the request and every stored entry. The index an entry got when it was written stays its physical page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_size_i | input | 2 | Page size code (R6) |
| os_mode_i | input | 1 | OS mode flag for translated accesses |
| wr_en_i | input | 1 | Load an entry from wr_word_i |
| wr_word_i | input | 23 | Packed entry word: page numbers and protection |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 25 | Logical address |
| req_write_i | input | 1 | Access is a write |
| req_trans_i | input | 1 | Translated (non-supervisor) access |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_hit_o | output | 1 | Some valid entry matched |
| rsp_abort_o | output | 1 | Miss or access denied |
| rsp_paddr_o | output | 22 | Physical address |

## Verification
Each entry is checked only through lookups, so a wrong internal state always shows up on the next request that reaches it. An entry stored at the wrong index shows up as a physical address with wrong upper bits. An entry with a stale or corrupt logical page shows up as an abort where a hit was due, or as a hit on a page nobody wrote. A corrupt protection code flips rsp_abort_o for OS or user writes while supervisor accesses still pass. All of these appear one cycle after the lookup that reaches the broken entry, so the bench follows every write with lookups aimed at written pages as well as at random ones.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int unsigned NUM_PAGES  = 128;
  localparam int unsigned PPN_W      = $clog2(NUM_PAGES);
  localparam int unsigned LADDR_W    = 25;
  localparam int unsigned PADDR_W    = 22;
  localparam int unsigned WORD_W     = 23;
  localparam int unsigned MIN_SHIFT  = 12;
  localparam int unsigned LPN_W      = LADDR_W - MIN_SHIFT;
  localparam int unsigned PROT_LSB   = 8;
  localparam int unsigned TAG_W      = WORD_W - PROT_LSB;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_8K  = 2'd1,
    PG_16K = 2'd2,
    PG_32K = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    AM_SUPER = 2'd0,
    AM_OS    = 2'd1,
    AM_USER  = 2'd2
  } acc_mode_e;

  function automatic logic [3:0] shift_of(pg_size_e s);
    return 4'(MIN_SHIFT) + {2'b00, s};
  endfunction

  function automatic logic [PPN_W-1:0] ppn_of(logic [WORD_W-1:0] w, pg_size_e s);
    unique case (s)
      PG_4K:   return w[6:0];
      PG_8K:   return {w[0], w[6:1]};
      PG_16K:  return {w[1:0], w[6:2]};
      default: return {w[1], w[2], w[0], w[6:3]};
    endcase
  endfunction

  // tag holds word bits [22:8]; tag[k] = word[k+8]
  function automatic logic [LPN_W-1:0] lpn_of(logic [TAG_W-1:0] t, pg_size_e s);
    unique case (s)
      PG_4K:   return {t[3:2], t[14:4]};
      PG_8K:   return {1'b0, t[3:2], t[14:5]};
      PG_16K:  return {2'b00, t[3:2], t[14:6]};
      default: return {3'b000, t[3:2], t[14:7]};
    endcase
  endfunction
endpackage

// File: rtl/pcx_entry_array.sv
module pcx_entry_array
  import pcx_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [WORD_W-1:0]              wr_word_i,
  input  pg_size_e                       page_size_i,
  output logic [NUM_PAGES-1:0]           valid_o,
  output logic [NUM_PAGES-1:0][TAG_W-1:0] tag_o
);
  logic [PPN_W-1:0] wr_idx;
  assign wr_idx = ppn_of(wr_word_i, page_size_i);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (wr_en_i && (wr_idx == PPN_W'(g))) begin
        v_q <= 1'b1;
        t_q <= wr_word_i[WORD_W-1:PROT_LSB];
      end
    end
    assign valid_o[g] = v_q;
    assign tag_o[g]   = t_q;
  end

  // R3: written entry is valid and holds the new word next cycle
  a_r3_write_sets_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_o[$past(wr_idx)] &&
                 (tag_o[$past(wr_idx)] == $past(wr_word_i[WORD_W-1:PROT_LSB]))));
endmodule

// File: rtl/pcx_match.sv
module pcx_match
  import pcx_pkg::*;
(
  input  logic [NUM_PAGES-1:0]            valid_i,
  input  logic [NUM_PAGES-1:0][TAG_W-1:0] tag_i,
  input  pg_size_e                        page_size_i,
  input  logic [LPN_W-1:0]                lpn_i,
  output logic                            hit_o,
  output logic [PPN_W-1:0]                ppn_o,
  output logic [1:0]                      prot_o
);
  logic [NUM_PAGES-1:0] match;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (lpn_of(tag_i[g], page_size_i) == lpn_i);
  end

  // descending scan: lowest matching index is written last and wins
  always_comb begin
    hit_o  = 1'b0;
    ppn_o  = '0;
    prot_o = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        ppn_o  = PPN_W'(i);
        prot_o = tag_i[i][1:0];
      end
    end
  end
endmodule

// File: rtl/pcx_perm.sv
module pcx_perm
  import pcx_pkg::*;
(
  input  acc_mode_e  mode_i,
  input  logic       write_i,
  input  logic [1:0] prot_i,
  output logic       allow_o
);
  always_comb begin
    unique case (mode_i)
      AM_SUPER: allow_o = 1'b1;
      AM_OS:    allow_o = !prot_i[1] || !write_i;
      AM_USER:  allow_o = (prot_i == 2'b00) || ((prot_i == 2'b01) && !write_i);
      default:  allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/page_cam_xlat.sv
module page_cam_xlat
  import pcx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         page_size_i,
  input  logic               os_mode_i,
  input  logic               wr_en_i,
  input  logic [WORD_W-1:0]  wr_word_i,
  input  logic               req_valid_i,
  input  logic [LADDR_W-1:0] req_addr_i,
  input  logic               req_write_i,
  input  logic               req_trans_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic               rsp_abort_o,
  output logic [PADDR_W-1:0] rsp_paddr_o
);
  pg_size_e  size;
  logic [3:0] shift;
  logic [LPN_W-1:0] req_lpn;
  acc_mode_e mode;

  assign size    = pg_size_e'(page_size_i);
  assign shift   = shift_of(size);
  assign req_lpn = LPN_W'(req_addr_i >> shift);
  assign mode    = !req_trans_i ? AM_SUPER : (os_mode_i ? AM_OS : AM_USER);

  logic [NUM_PAGES-1:0]            ent_valid;
  logic [NUM_PAGES-1:0][TAG_W-1:0] ent_tag;

  pcx_entry_array u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_word_i   (wr_word_i),
    .page_size_i (size),
    .valid_o     (ent_valid),
    .tag_o       (ent_tag)
  );

  logic             m_hit;
  logic [PPN_W-1:0] m_ppn;
  logic [1:0]       m_prot;

  pcx_match u_match (
    .valid_i     (ent_valid),
    .tag_i       (ent_tag),
    .page_size_i (size),
    .lpn_i       (req_lpn),
    .hit_o       (m_hit),
    .ppn_o       (m_ppn),
    .prot_o      (m_prot)
  );

  logic allow;

  pcx_perm u_perm (
    .mode_i  (mode),
    .write_i (req_write_i),
    .prot_i  (m_prot),
    .allow_o (allow)
  );

  logic [PADDR_W-1:0] off_mask, paddr_d;
  assign off_mask = (PADDR_W'(1) << shift) - PADDR_W'(1);
  assign paddr_d  = (PADDR_W'(m_ppn) << shift) | (PADDR_W'(req_addr_i) & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_abort_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && m_hit;
      rsp_abort_o <= req_valid_i && (!m_hit || !allow);
      rsp_paddr_o <= (req_valid_i && m_hit) ? paddr_d : '0;
    end
  end

  a_r2_rsp_tracks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_abort_o && (rsp_paddr_o == '0)));

  a_r9_miss_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_abort_o && (rsp_paddr_o == '0)));

  a_r7_super_never_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_trans_i) |=> (rsp_abort_o == !rsp_hit_o));
endmodule

// File: tb/page_cam_xlat_tb.sv
module page_cam_xlat_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  page_size = 2'd0;
  logic        os_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [22:0] wr_word = '0;
  logic        req_valid = 1'b0;
  logic [24:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_trans = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_abort;
  logic [21:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_cam_xlat u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .page_size_i(page_size), .os_mode_i(os_mode),
    .wr_en_i(wr_en), .wr_word_i(wr_word), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_trans_i(req_trans), .rsp_valid_o(rsp_valid),
    .rsp_hit_o(rsp_hit), .rsp_abort_o(rsp_abort), .rsp_paddr_o(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;
  bit mvalid [128];
  logic [14:0] mtag [128];

  task automatic chk(input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", name, act, exp);
    end
  endtask

  function automatic int b_shift(input logic [1:0] sz);
    return 12 + int'(sz);
  endfunction

  function automatic logic [6:0] b_ppn(input logic [22:0] w, input logic [1:0] sz);
    logic [6:0] lo = w[6:0];
    case (sz)
      2'd0: return lo;
      2'd1: return (lo >> 1) | (7'(w[0]) << 6);
      2'd2: return (lo >> 2) | (7'(w[1:0]) << 5);
      default: return 7'((lo >> 3) & 7'hF) | (7'(w[0]) << 4) | (7'(w[2]) << 5) | (7'(w[1]) << 6);
    endcase
  endfunction

  function automatic logic [12:0] b_lpn(input logic [14:0] t, input logic [1:0] sz);
    int sh = b_shift(sz);
    return 13'(t >> (sh - 8)) | (13'(t[3:2]) << (11 - int'(sz)));
  endfunction

  function automatic bit b_allow(input logic tr, input logic os, input logic wr, input logic [1:0] p);
    if (!tr) return 1'b1;
    if (os) return (p == 2'b00) || (p == 2'b01) || !wr;
    return (p == 2'b00) || (p == 2'b01 && !wr);
  endfunction

  task automatic model_rsp(input logic [24:0] a, input logic wr, input logic tr, input logic os,
                           output logic e_hit, output logic e_ab, output logic [21:0] e_pa);
    int sh = b_shift(page_size);
    logic [12:0] lp = 13'(a >> sh);
    int idx = -1;
    for (int i = 0; i < 128; i++)
      if (idx < 0 && mvalid[i] && b_lpn(mtag[i], page_size) == lp) idx = i;
    e_hit = (idx >= 0);
    e_pa  = '0;
    e_ab  = 1'b1;
    if (e_hit) begin
      e_pa = 22'((idx << sh) | (int'(a) & ((1 << sh) - 1)));
      e_ab = !b_allow(tr, os, wr, mtag[idx][1:0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 128; i++) begin mvalid[i] = 1'b0; mtag[i] = '0; end
    chk("R1 reset valid", rsp_valid, 0);
    chk("R1 reset abort", rsp_abort, 0);
    chk("R1 reset paddr", rsp_paddr, 0);
    rst_ni = 1'b1;
  endtask

  task automatic wr_entry(input logic [22:0] w);
    logic [6:0] p = b_ppn(w, page_size);
    @(negedge clk);
    wr_en = 1'b1;
    wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
    mvalid[p] = 1'b1;
    mtag[p] = w[22:8];
  endtask

  task automatic lookup(input logic [24:0] a, input logic wr, input logic tr, input logic os,
                        input string rq, output logic o_hit, output logic o_ab,
                        output logic [21:0] o_pa);
    logic e_hit, e_ab;
    logic [21:0] e_pa;
    model_rsp(a, wr, tr, os, e_hit, e_ab, e_pa);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_trans = tr; os_mode = os;
    @(negedge clk);
    chk({rq, " R2 valid"}, rsp_valid, 1);
    chk({rq, " hit"}, rsp_hit, e_hit);
    chk({rq, " abort"}, rsp_abort, e_ab);
    chk({rq, " paddr"}, rsp_paddr, e_pa);
    o_hit = rsp_hit; o_ab = rsp_abort; o_pa = rsp_paddr;
    req_valid = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic h, ab;
    logic [21:0] pa;
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R1 / R9: empty table misses
    page_size = 2'd0;
    lookup(25'h0123456, 1'b0, 1'b0, 1'b0, "R1 R9 empty", h, ab, pa);
    chk("R9 miss hit", h, 0);
    chk("R9 miss abort", ab, 1);
    chk("R9 miss paddr", pa, 0);

    // R2: idle cycle after a request is quiet
    @(negedge clk);
    chk("R2 idle valid", rsp_valid, 0);
    chk("R2 idle abort", rsp_abort, 0);

    // R3 R5 R6: 4 KB entry, PPN 5, LPN 0x1123
    wr_entry(23'h123805);
    lookup(25'h1123ABC, 1'b0, 1'b0, 1'b0, "R6 4K super read", h, ab, pa);
    chk("R6 4K paddr", pa, 22'h005ABC);
    chk("R3 4K hit", h, 1);
    lookup(25'h1123ABC, 1'b1, 1'b1, 1'b0, "R8 prot00 user write", h, ab, pa);
    chk("R8 prot00 user write allowed", ab, 0);

    // R8: prot 01 at PPN 6
    wr_entry(23'h200106);
    lookup(25'h0200010, 1'b1, 1'b1, 1'b0, "R8 prot01 user write", h, ab, pa);
    chk("R8 prot01 user write denied", ab, 1);
    chk("R9 denied still hits", h, 1);
    lookup(25'h0200010, 1'b0, 1'b1, 1'b0, "R8 prot01 user read", h, ab, pa);
    chk("R8 prot01 user read allowed", ab, 0);
    lookup(25'h0200010, 1'b1, 1'b1, 1'b1, "R8 prot01 os write", h, ab, pa);
    chk("R8 prot01 os write allowed", ab, 0);

    // R8 R7: prot 10 at PPN 7
    wr_entry(23'h300207);
    lookup(25'h0300000, 1'b1, 1'b1, 1'b1, "R8 prot10 os write", h, ab, pa);
    chk("R8 prot10 os write denied", ab, 1);
    lookup(25'h0300000, 1'b0, 1'b1, 1'b1, "R8 prot10 os read", h, ab, pa);
    chk("R8 prot10 os read allowed", ab, 0);
    lookup(25'h0300000, 1'b0, 1'b1, 1'b0, "R8 prot10 user read", h, ab, pa);
    chk("R8 prot10 user read denied", ab, 1);
    lookup(25'h0300000, 1'b1, 1'b0, 1'b1, "R7 super write prot10", h, ab, pa);
    chk("R7 super write allowed", ab, 0);

    // R10: same LPN at PPN 9 and 3, lowest wins
    wr_entry(23'h400009);
    wr_entry(23'h400003);
    lookup(25'h0400044, 1'b0, 1'b0, 1'b0, "R10 lowest wins", h, ab, pa);
    chk("R10 paddr", pa, 22'h003044);

    // R3: replace PPN 3 with another LPN; PPN 9 now serves LPN 0x400
    wr_entry(23'h500003);
    lookup(25'h0400044, 1'b0, 1'b0, 1'b0, "R3 replaced", h, ab, pa);
    chk("R3 replace paddr", pa, 22'h009044);

    // R4 R6: 32 KB, PPN 0x55, LPN 0x12A
    do_reset();
    page_size = 2'd3;
    wr_entry(23'h15042B);
    lookup(25'h0951234, 1'b0, 1'b0, 1'b0, "R4 32K", h, ab, pa);
    chk("R4 32K paddr", pa, 22'h2A9234);

    // R11: written under 4 KB at index 0x11, looked up under 8 KB
    do_reset();
    page_size = 2'd0;
    wr_entry(23'h004011);
    page_size = 2'd1;
    lookup(25'h0004010, 1'b0, 1'b0, 1'b0, "R11 size change", h, ab, pa);
    chk("R11 paddr", pa, 22'h022010);

    // random mix: R4 R5 R6 R8 R10 against the bench model
    do_reset();
    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 4) begin
        page_size = 2'($urandom_range(0, 3));
      end else if (r < 30) begin
        wr_entry(23'($urandom));
      end else begin
        logic [24:0] a = 25'($urandom);
        int i = int'($urandom_range(0, 127));
        if (r < 80 && mvalid[i]) begin
          int sh = b_shift(page_size);
          a = 25'((int'(b_lpn(mtag[i], page_size)) << sh) | (int'($urandom) & ((1 << sh) - 1)));
        end
        lookup(a, 1'($urandom), 1'($urandom), 1'($urandom),
               "R4/R5/R6/R8 random", h, ab, pa);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule